// File: doc/BRIEF.md
# Dual Programmable Interval Counter

This block holds two 16-bit down-counters of the classic interval-timer type, named counter 0 and counter 2. Both sit behind a single byte-wide register port. An internal prescaler turns the core clock into a count-enable tick close to 1.19318 MHz. Each enabled counter subtracts one on every tick.

Software programs a counter in three steps. It writes a control byte, then the low byte of the count, then the high byte. The count is loaded and starts running only when the second byte arrives. A control byte can also take a snapshot of a running count, so that the two bytes read back belong to the same value.

In mode 0 the counter stops at zero and raises a terminal-count flag. The flag for counter 2 can be read at the control address. In every other mode the counter wraps around and keeps running.

Register addresses (`bus_addr`):
- 0 is counter 0 data.
- 1 is counter 2 data.
- 2 is the control byte on a write and counter 2 status on a read.
- 3 reads as zero.

Control byte fields:
- Bits 7:6 select the counter: 0 is counter 0, 2 is counter 2.
- Bits 5:4 give the access code: 00 takes a snapshot, 11 starts a low/high load.
- Bits 3:1 give the operating mode.

Each counter has three state machines:
- **Run machine.** States are IDLE, COUNT and EXPIRED. Loading a count moves any state to COUNT. COUNT moves to EXPIRED when a tick meets a count of 1 in mode 0.
- **Load machine.** States are LD_LOW and LD_HIGH. Each data write toggles it. A low/high control byte forces it to LD_LOW.
- **Read machine.** States are RD_LOW and RD_HIGH. A data read in RD_LOW moves it to RD_HIGH. A read in RD_HIGH returns to RD_LOW only when a snapshot is being released. A snapshot command or a low/high control byte forces it to RD_LOW.

Top module: `ivt_pair`

## Requirements
- R1: A control write decodes bits 7:6 as the counter select (0 is counter 0, 2 is counter 2), bits 5:4 as the access code and bits 3:1 as the operating mode. Access code 11 sets the selected counter's mode and restarts its load sequence at the low byte.
- R2: A control write with select 1 or 3, or with access code 01 or 10, changes no counter state. It drives `cfg_err` high for exactly one cycle, starting with the clock edge that takes the write.
- R3: The first data write after a low/high control byte stores only the low byte, and the counter keeps its previous count and state. The second write loads {high, low} as the count and starts counting.
- R4: Each counter keeps its own low/high sequence, so writes to the two counters may be interleaved.
- R5: A running counter decreases by exactly one per tick. A tick occurs once every `TICK_DIV` clock cycles.
- R6: Access code 00 copies the live count into a snapshot, unless a snapshot is already pending. The next two data reads return the snapshot low byte and then the high byte, and reading the high byte releases the snapshot. A repeated snapshot command while one is pending is ignored.
- R7: With no snapshot pending, the first data read returns the live low byte and every later read returns the live high byte.
- R8: In mode 0, the tick that takes the count from 1 to 0 sets status bit 5, giving a status value of 0x20, and the count then stays at 0.
- R9: In modes other than 0 the count wraps from 0 to 0xFFFF and keeps running, and status stays 0.
- R10: Loading a new count clears the status byte to 0.
- R11: After reset both counts are 0 and stopped, status is 0, `bus_rdata` is 0, `cfg_err` is 0, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; may have side effects |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after `bus_rd` |
| cfg_err | output | 1 | One-cycle pulse on an unsupported control byte |

## Verification
The hardest state to reach from the ports is a snapshot that stays frozen while the live count keeps moving, and that ignores a second snapshot command. The bench records the clock cycle of every load and every snapshot command. It then checks each value read back against a window of ticks computed from those cycle counts. This shows that the value came from the first command and not the second.

Mode-0 expiry is the only place where the count is exactly known while time passes. The bench therefore drives counter 2 to expiry and reads the frozen zero several times. It then reloads the counter to show that the status clears.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int N_CHAN = 2;

    localparam logic [1:0] ADDR_CNT0 = 2'd0;
    localparam logic [1:0] ADDR_CNT2 = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam logic [1:0] ACC_SNAP = 2'b00;
    localparam logic [1:0] ACC_LOHI = 2'b11;

    localparam int STATUS_TC_BIT = 5;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_COUNT,
        RUN_EXPIRED
    } run_state_e;

    typedef enum logic {
        LD_LOW,
        LD_HIGH
    } load_state_e;

    typedef enum logic {
        RD_LOW,
        RD_HIGH
    } read_state_e;

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
    parameter int TICK_DIV = 84
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           pre_q <= '0;
                else if (pre_q == LAST) pre_q <= '0;
                else                  pre_q <= pre_q + PW'(1);
            end

            assign tick = (pre_q == LAST);

            // R5: ticks are spaced by the divider, never back to back
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctl_fire,
    input  logic [1:0]        ctl_acc,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              wr_fire,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_fire,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] status
);
    run_state_e  run_q, run_d;
    load_state_e ld_q, ld_d;
    read_state_e rd_q, rd_d;

    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  snap_q, snap_d;
    logic [BYTE_W-1:0] lo_q, lo_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic              snap_on_q, snap_on_d;
    logic              tc_q, tc_d;

    logic load_fire, lohi_cmd, snap_cmd;

    assign lohi_cmd  = ctl_fire && (ctl_acc == ACC_LOHI);
    assign snap_cmd  = ctl_fire && (ctl_acc == ACC_SNAP);
    assign load_fire = wr_fire && (ld_q == LD_HIGH);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= RUN_IDLE;
            ld_q      <= LD_LOW;
            rd_q      <= RD_LOW;
            cnt_q     <= '0;
            snap_q    <= '0;
            lo_q      <= '0;
            mode_q    <= '0;
            snap_on_q <= 1'b0;
            tc_q      <= 1'b0;
        end else begin
            run_q     <= run_d;
            ld_q      <= ld_d;
            rd_q      <= rd_d;
            cnt_q     <= cnt_d;
            snap_q    <= snap_d;
            lo_q      <= lo_d;
            mode_q    <= mode_d;
            snap_on_q <= snap_on_d;
            tc_q      <= tc_d;
        end
    end

    // run machine: counting and terminal count
    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        tc_d  = tc_q;
        unique case (run_q)
            RUN_IDLE: begin
            end
            RUN_COUNT: begin
                if (tick) begin
                    cnt_d = cnt_q - CNT_W'(1);
                    if ((mode_q == '0) && (cnt_q == CNT_W'(1))) begin
                        run_d = RUN_EXPIRED;
                        tc_d  = 1'b1;
                    end
                end
            end
            RUN_EXPIRED: begin
            end
            default: run_d = RUN_IDLE;
        endcase
        if (load_fire) begin
            cnt_d = {wdata, lo_q};
            run_d = RUN_COUNT;
            tc_d  = 1'b0;
        end
    end

    // load machine: low byte first, high byte loads
    always_comb begin
        ld_d   = ld_q;
        lo_d   = lo_q;
        mode_d = mode_q;
        if (lohi_cmd) begin
            ld_d   = LD_LOW;
            mode_d = ctl_mode;
        end else if (wr_fire) begin
            unique case (ld_q)
                LD_LOW: begin
                    lo_d = wdata;
                    ld_d = LD_HIGH;
                end
                LD_HIGH: ld_d = LD_LOW;
                default: ld_d = LD_LOW;
            endcase
        end
    end

    // read machine: snapshot and byte sequencing
    always_comb begin
        rd_d      = rd_q;
        snap_d    = snap_q;
        snap_on_d = snap_on_q;
        if (snap_cmd) begin
            if (!snap_on_q) begin
                snap_on_d = 1'b1;
                snap_d    = cnt_q;
                rd_d      = RD_LOW;
            end
        end else if (lohi_cmd) begin
            rd_d = RD_LOW;
        end else if (rd_fire) begin
            unique case (rd_q)
                RD_LOW: rd_d = RD_HIGH;
                RD_HIGH: begin
                    if (snap_on_q) begin
                        snap_on_d = 1'b0;
                        rd_d      = RD_LOW;
                    end
                end
                default: rd_d = RD_LOW;
            endcase
        end
    end

    // output process
    logic [CNT_W-1:0] src;
    always_comb begin
        src    = snap_on_q ? snap_q : cnt_q;
        rd_byte = (rd_q == RD_LOW) ? src[BYTE_W-1:0] : src[CNT_W-1:BYTE_W];
        status = '0;
        status[STATUS_TC_BIT] = tc_q;
    end

    // R5: one decrement per tick while counting
    assert_dec_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_COUNT && tick && !load_fire) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8: an expired counter sits at zero
    assert_stop_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_EXPIRED) |-> (cnt_q == '0));

    // R9: terminal count only ever rises in mode 0
    assert_tc_mode0_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_q) |-> (mode_q == '0));

    // R6: a pending snapshot does not move
    assert_snap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_on_q && $past(snap_on_q)) |-> $stable(snap_q));

    // R10: a load leaves the status clear
    assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> !tc_q);

endmodule

// File: rtl/ivt_pair.sv
module ivt_pair
    import ivt_pkg::*;
#(
    parameter int TICK_DIV = 84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              cfg_err
);
    logic tick;

    ivt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    logic [1:0]        cw_sel, cw_acc;
    logic [MODE_W-1:0] cw_mode;
    logic              ctrl_wr, cw_ok;

    assign cw_sel  = bus_wdata[7:6];
    assign cw_acc  = bus_wdata[5:4];
    assign cw_mode = bus_wdata[3:1];
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign cw_ok   = ((cw_sel == 2'd0) || (cw_sel == 2'd2)) &&
                     ((cw_acc == ACC_SNAP) || (cw_acc == ACC_LOHI));

    logic [N_CHAN-1:0]  ctl_fire, wr_fire, rd_fire;
    logic [BYTE_W-1:0]  rd_byte [N_CHAN];
    logic [BYTE_W-1:0]  status  [N_CHAN];

    generate
        for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
            localparam logic [1:0] SEL_CODE = 2'(2 * i);
            localparam logic [1:0] DATA_ADR = (i == 0) ? ADDR_CNT0 : ADDR_CNT2;

            assign ctl_fire[i] = ctrl_wr && cw_ok && (cw_sel == SEL_CODE);
            assign wr_fire[i]  = bus_wr && (bus_addr == DATA_ADR);
            assign rd_fire[i]  = bus_rd && (bus_addr == DATA_ADR);

            ivt_channel u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .ctl_fire(ctl_fire[i]),
                .ctl_acc (cw_acc),
                .ctl_mode(cw_mode),
                .wr_fire (wr_fire[i]),
                .wdata   (bus_wdata),
                .rd_fire (rd_fire[i]),
                .rd_byte (rd_byte[i]),
                .status  (status[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_err <= ctrl_wr && !cw_ok;
            if (bus_rd) begin
                unique case (bus_addr)
                    ADDR_CNT0: bus_rdata <= rd_byte[0];
                    ADDR_CNT2: bus_rdata <= rd_byte[1];
                    ADDR_CTRL: bus_rdata <= status[1];
                    default:   bus_rdata <= '0;
                endcase
            end
        end
    end

    // R1: at most one counter accepts a given control byte
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_fire));

    // R2: an error pulse always follows a control write
    assert_err_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(bus_wr && (bus_addr == ADDR_CTRL)));

endmodule

// File: tb/ivt_pair_tb.sv
module ivt_pair_tb;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cfg_err;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    ivt_pair #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, output int at);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        at = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd16(input logic [1:0] a, output int v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a, hi);
        v = {16'd0, hi, lo};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected decrement over an elapsed cycle span, tolerance of two ticks
    task automatic chk_span(input string tag, input int start, input int now_v,
                            input int t0, input int t1);
        int dec, exp;
        dec = (start - now_v) & 16'hFFFF;
        exp = (t1 - t0) / DIV;
        chk(dec >= exp - 2 && dec <= exp + 2, tag, dec, exp);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] b, h;
        int v, v2, t, t_ld, t_s1, t_s3, t_a, t_b;

        idle(3);
        chk(bus_rdata == 0 && cfg_err == 0, "R11 outputs at reset", bus_rdata, 0);
        rst_n = 1'b1;
        idle(2);
        // R11 reset reads
        rd16(2'd0, v); chk(v == 0, "R11 counter0 reset", v, 0);
        rd16(2'd1, v); chk(v == 0, "R11 counter2 reset", v, 0);
        rd(2'd2, b);   chk(b == 0, "R11 status reset", b, 0);
        rd(2'd3, b);   chk(b == 0, "R11 address 3", b, 0);

        // R3: first byte alone does not start counter 0
        wr(2'd2, 8'h34, t);
        wr(2'd0, 8'h55, t);
        idle(40);
        wr(2'd2, 8'h00, t);
        rd16(2'd0, v); chk(v == 0, "R3 no run after low byte", v, 0);
        wr(2'd0, 8'h80, t_ld);
        idle(60);
        wr(2'd2, 8'h00, t_s1);
        rd16(2'd0, v);
        chk_span("R3 R5 load and count", 16'h8055, v, t_ld, t_s1);

        // R6: snapshot frozen, duplicate command ignored
        wr(2'd2, 8'h00, t_s1);
        idle(60);
        wr(2'd2, 8'h00, t);
        idle(30);
        rd16(2'd0, v);
        chk_span("R6 first snapshot kept", 16'h8055, v, t_ld, t_s1);
        wr(2'd2, 8'h00, t_s3);
        rd16(2'd0, v2);
        chk_span("R6 release and resnap", v, v2, t_s1, t_s3);

        // R7: unlatched reads, low then high, high repeats
        rd(2'd0, b); rd(2'd0, h);
        t = cyc;
        chk_span("R7 live low then high", 16'h8055, {16'd0, h, b}, t_ld, t);
        rd(2'd0, b);
        chk(b == h, "R7 high byte repeats", b, h);

        // R8: mode 0 expiry on counter 2
        wr(2'd2, 8'hB0, t);
        wr(2'd1, 8'd20, t);
        wr(2'd1, 8'd0, t_ld);
        idle(12);
        rd(2'd2, b); chk(b == 8'h00, "R8 status before expiry", b, 0);
        idle(100);
        rd(2'd2, b); chk(b == 8'h20, "R8 status at expiry", b, 8'h20);
        wr(2'd2, 8'h80, t);
        rd16(2'd1, v); chk(v == 0, "R8 count held at zero", v, 0);
        idle(40);
        wr(2'd2, 8'h80, t);
        rd16(2'd1, v); chk(v == 0, "R8 still zero later", v, 0);

        // R10: reload clears status
        wr(2'd1, 8'h00, t);
        wr(2'd1, 8'h10, t_ld);
        rd(2'd2, b); chk(b == 8'h00, "R10 status cleared", b, 0);
        idle(30);
        wr(2'd2, 8'h80, t);
        rd16(2'd1, v);
        chk_span("R10 reload runs", 16'h1000, v, t_ld, t);

        // R9: mode 2 wraps and keeps running, no status
        wr(2'd2, 8'hB4, t);
        wr(2'd1, 8'd5, t);
        wr(2'd1, 8'd0, t_ld);
        idle(60);
        rd(2'd2, b); chk(b == 8'h00, "R9 no status in mode 2", b, 0);
        wr(2'd2, 8'h80, t);
        rd16(2'd1, v);
        chk(v > 16'hFF00, "R9 wrapped past zero", v, 16'hFFF0);
        chk_span("R9 wrap span", 5, v, t_ld, t);

        // R2: unsupported control bytes, no effect on an open load sequence
        wr(2'd2, 8'h34, t);
        wr(2'd0, 8'h00, t);
        wr(2'd2, 8'h74, t);
        chk(cfg_err == 1'b1, "R2 select 1 flagged", cfg_err, 1);
        idle(1);
        chk(cfg_err == 1'b0, "R2 pulse one cycle", cfg_err, 0);
        wr(2'd2, 8'h10, t);
        chk(cfg_err == 1'b1, "R2 access 01 flagged", cfg_err, 1);
        wr(2'd2, 8'hC4, t);
        chk(cfg_err == 1'b1, "R2 select 3 flagged", cfg_err, 1);
        wr(2'd0, 8'h40, t_ld);
        idle(20);
        wr(2'd2, 8'h00, t);
        rd16(2'd0, v);
        chk_span("R2 load sequence undisturbed", 16'h4000, v, t_ld, t);

        // R1 R4: interleaved programming of both counters
        wr(2'd2, 8'h34, t);
        wr(2'd2, 8'hB4, t);
        wr(2'd0, 8'h00, t);
        wr(2'd1, 8'h00, t);
        wr(2'd0, 8'h30, t_a);
        wr(2'd1, 8'h60, t_b);
        idle(25);
        wr(2'd2, 8'h00, t);
        rd16(2'd0, v);
        chk_span("R4 counter0 interleaved", 16'h3000, v, t_a, t);
        wr(2'd2, 8'h80, t);
        rd16(2'd1, v);
        chk_span("R1 R4 counter2 interleaved", 16'h6000, v, t_b, t);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule